// File: doc/BRIEF.md
# Flash Status Register Controller

This block holds the 8-bit status byte of a NOR-style flash command interface and returns it on the byte-wide data bus. An internal program/erase sequencer sends it single-cycle pulses: operation start, operation done, suspend entered, suspend left, erase failed and program failed. A supply-good input is sampled each time a program or erase confirm is accepted. Host bus writes are decoded for two opcodes, one that enters status-read mode and one that clears the error flags.

While status-read mode is active, every read cycle (chip enable and output enable both low) returns the status byte without a new command. The byte is captured on the first cycle of the read and held until chip enable or output enable goes high and then low again. The three error flags are sticky. While any error flag is set, the `lockout` output tells the neighbouring command decoder to refuse new program and erase requests. The active-low reset/power-down pin returns the block to its reset state.

All pins are sampled on `clk`. The block uses a synchronous active-high `rst`, and `pwrdn_n` low acts as a second synchronous reset.

Top module: `flash_status_ctrl`

## Requirements
- R1: The status byte has this layout: bit 7 ready (1 = sequencer idle), bit 6 erase suspended, bit 5 erase error, bit 4 program error, bit 3 supply error. Bits 2..0 always read 0. After reset the byte is 0x80.
- R2: A bus write of opcode 0x70 puts the block in status-read mode. In that mode, a cycle with `ce_n` and `oe_n` both low gives `dout_en`=1 and the status byte on `dout` one clock later. In all other cycles `dout_en`=0 and `dout`=0x00.
- R3: Once a read has started, `dout` keeps its captured value while `ce_n` and `oe_n` stay low, even if the status changes. A new capture happens only after one of them goes high and both are low again.
- R4: The erase-error, program-error and supply-error bits stay set until a bus write of opcode 0x50 or a reset. The sequencer has no way to clear them.
- R5: The ready bit changes only on sequencer pulses. `seq_start` clears it and `seq_done` sets it, with start winning if both arrive together. The suspend bit is set by `seq_susp_set` and cleared by `seq_susp_clr`. Opcode 0x50 leaves both bits unchanged.
- R6: `lockout` is 1 exactly while at least one of the three error bits is set.
- R7: `pwrdn_n` low for a clock cycle returns the status byte to 0x80, drops `lockout` and leaves status-read mode.
- R8: The supply-error bit is set only at a cycle where `op_confirm`=1 and `vpp_ok`=0. Changes of `vpp_ok` at other times have no effect.
- R9: An error-set pulse in the same cycle as a 0x50 command wins, so the bit stays set.
- R10: Any opcode other than 0x70 and 0x50 leaves status-read mode unchanged, and 0x50 written outside that mode does not enter it. A command is taken once per write strobe (the first cycle of `ce_n`/`we_n` both low).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwrdn_n | input | 1 | Active-low reset/power-down pin |
| ce_n | input | 1 | Active-low chip enable |
| oe_n | input | 1 | Active-low output enable |
| we_n | input | 1 | Active-low write enable |
| din | input | 8 | Command byte from the data bus |
| dout | output | 8 | Status byte driven during reads |
| dout_en | output | 1 | High while `dout` carries a valid status read |
| seq_start | input | 1 | Pulse: sequencer started an operation (busy) |
| seq_done | input | 1 | Pulse: sequencer finished (ready) |
| seq_susp_set | input | 1 | Pulse: erase suspended |
| seq_susp_clr | input | 1 | Pulse: erase resumed or ended |
| seq_erase_fail | input | 1 | Pulse: erase verify exhausted |
| seq_prog_fail | input | 1 | Pulse: program verify exhausted |
| op_confirm | input | 1 | Pulse: program/erase confirm accepted |
| vpp_ok | input | 1 | Programming supply present |
| lockout | output | 1 | Refuse new program/erase while high |

## Verification
On every cycle the assertions check these properties: an error bit falls only after a clear command or a reset; `lockout` is held while no clear arrives; a read in progress never changes `dout`; the reserved bits stay zero; the supply-error bit rises only from a failed confirm sample; the ready bit rises only from a done pulse; read mode once entered is kept; and a power-down returns 0x80. Some behaviour can only be shown by the bench's scenarios against its reference model: the exact status values after mixed sequencer pulses, the fresh capture after toggling output enable, set-over-clear priority in one cycle, and the handling of unknown opcodes or commands written outside read mode.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
  localparam int SR_W    = 8;
  localparam int N_ERR   = 3;
  localparam int B_READY = 7;
  localparam int B_SUSP  = 6;
  localparam int B_EERR  = 5;
  localparam int B_PERR  = 4;
  localparam int B_VERR  = 3;

  // err index: 2 = erase, 1 = program, 0 = supply
  localparam int E_ERASE = 2;
  localparam int E_PROG  = 1;
  localparam int E_SUPPLY = 0;

  typedef struct packed {
    logic             ready;
    logic             susp;
    logic [N_ERR-1:0] err;
  } sr_state_t;

  function automatic logic [SR_W-1:0] sr_pack(sr_state_t s);
    logic [SR_W-1:0] v;
    v          = '0;
    v[B_READY] = s.ready;
    v[B_SUSP]  = s.susp;
    v[B_EERR]  = s.err[E_ERASE];
    v[B_PERR]  = s.err[E_PROG];
    v[B_VERR]  = s.err[E_SUPPLY];
    return v;
  endfunction
endpackage

// File: rtl/fsr_sticky_flag.sv
module fsr_sticky_flag (
  input  logic clk,
  input  logic rst_i,
  input  logic set_i,
  input  logic clr_i,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst_i)      q <= 1'b0;
    else if (set_i) q <= 1'b1;
    else if (clr_i) q <= 1'b0;
  end

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst_i)
    $fell(q) |-> ($past(clr_i) || $past(rst_i))); // R4

  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst_i)
    set_i |=> q); // R9
endmodule

// File: rtl/fsr_bus_decode.sv
module fsr_bus_decode #(
  parameter int          OP_W     = 8,
  parameter logic [7:0]  OP_RDSR  = 8'h70,
  parameter logic [7:0]  OP_CLRSR = 8'h50
) (
  input  logic            clk,
  input  logic            rst_i,
  input  logic            ce_n,
  input  logic            we_n,
  input  logic [OP_W-1:0] din,
  output logic            clr_cmd,
  output logic            rd_mode
);
  logic wr_act, wr_q, wr_pulse;

  assign wr_act   = ~ce_n & ~we_n;
  assign wr_pulse = wr_act & ~wr_q;
  assign clr_cmd  = wr_pulse && (din == OP_W'(OP_CLRSR));

  always_ff @(posedge clk) begin
    if (rst_i) begin
      wr_q    <= 1'b0;
      rd_mode <= 1'b0;
    end else begin
      wr_q <= wr_act;
      if (wr_pulse && (din == OP_W'(OP_RDSR)))
        rd_mode <= 1'b1;
    end
  end

  AST_MODE_KEEP: assert property (@(posedge clk) disable iff (rst_i)
    rd_mode |=> rd_mode); // R10

  AST_ONE_CMD_PER_STROBE: assert property (@(posedge clk) disable iff (rst_i)
    clr_cmd |=> !clr_cmd); // R10
endmodule

// File: rtl/fsr_status_core.sv
module fsr_status_core
  import fsr_pkg::*;
(
  input  logic            clk,
  input  logic            rst_i,
  input  logic            seq_start,
  input  logic            seq_done,
  input  logic            seq_susp_set,
  input  logic            seq_susp_clr,
  input  logic            seq_erase_fail,
  input  logic            seq_prog_fail,
  input  logic            op_confirm,
  input  logic            vpp_ok,
  input  logic            clr_cmd,
  output logic [SR_W-1:0] status,
  output logic            lockout
);
  sr_state_t        st;
  logic [N_ERR-1:0] err_set;
  logic [N_ERR-1:0] err_q;

  assign err_set[E_ERASE]  = seq_erase_fail;
  assign err_set[E_PROG]   = seq_prog_fail;
  assign err_set[E_SUPPLY] = op_confirm & ~vpp_ok;

  for (genvar i = 0; i < N_ERR; i++) begin : g_err
    fsr_sticky_flag u_flag (
      .clk   (clk),
      .rst_i (rst_i),
      .set_i (err_set[i]),
      .clr_i (clr_cmd),
      .q     (err_q[i])
    );
  end

  logic ready_q, susp_q;

  always_ff @(posedge clk) begin
    if (rst_i) begin
      ready_q <= 1'b1;
      susp_q  <= 1'b0;
    end else begin
      if (seq_start)     ready_q <= 1'b0;
      else if (seq_done) ready_q <= 1'b1;
      if (seq_susp_set)      susp_q <= 1'b1;
      else if (seq_susp_clr) susp_q <= 1'b0;
    end
  end

  assign st.ready = ready_q;
  assign st.susp  = susp_q;
  assign st.err   = err_q;
  assign status   = sr_pack(st);
  assign lockout  = |err_q;

  AST_READY_SRC: assert property (@(posedge clk) disable iff (rst_i)
    $rose(status[B_READY]) |-> ($past(seq_done) || $past(rst_i))); // R5

  AST_VERR_SAMPLE: assert property (@(posedge clk) disable iff (rst_i)
    $rose(status[B_VERR]) |-> $past(op_confirm && !vpp_ok)); // R8

  AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (rst_i)
    (lockout && !clr_cmd) |=> lockout); // R6

  AST_RESET_VALUE: assert property (@(posedge clk)
    rst_i |=> (status == 8'h80)); // R7
endmodule

// File: rtl/fsr_read_port.sv
module fsr_read_port #(
  parameter int SR_W = 8
) (
  input  logic            clk,
  input  logic            rst_i,
  input  logic            rd_mode,
  input  logic            ce_n,
  input  logic            oe_n,
  input  logic [SR_W-1:0] status,
  output logic [SR_W-1:0] dout,
  output logic            dout_en
);
  logic rd_act, rd_q;

  assign rd_act = rd_mode & ~ce_n & ~oe_n;

  always_ff @(posedge clk) begin
    if (rst_i) begin
      rd_q    <= 1'b0;
      dout    <= '0;
      dout_en <= 1'b0;
    end else begin
      rd_q    <= rd_act;
      dout_en <= rd_act;
      if (!rd_act)    dout <= '0;
      else if (!rd_q) dout <= status;
    end
  end

  AST_READ_FROZEN: assert property (@(posedge clk) disable iff (rst_i)
    (rd_act && rd_q) |=> $stable(dout)); // R3

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst_i)
    dout[2:0] == 3'b000); // R1

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst_i)
    !rd_act |=> (!dout_en && dout == '0)); // R2
endmodule

// File: rtl/flash_status_ctrl.sv
module flash_status_ctrl
  import fsr_pkg::*;
#(
  parameter logic [7:0] OP_RDSR  = 8'h70,
  parameter logic [7:0] OP_CLRSR = 8'h50
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       pwrdn_n,
  input  logic       ce_n,
  input  logic       oe_n,
  input  logic       we_n,
  input  logic [7:0] din,
  output logic [7:0] dout,
  output logic       dout_en,
  input  logic       seq_start,
  input  logic       seq_done,
  input  logic       seq_susp_set,
  input  logic       seq_susp_clr,
  input  logic       seq_erase_fail,
  input  logic       seq_prog_fail,
  input  logic       op_confirm,
  input  logic       vpp_ok,
  output logic       lockout
);
  logic            rst_i;
  logic            clr_cmd;
  logic            rd_mode;
  logic [SR_W-1:0] status;

  assign rst_i = rst | ~pwrdn_n;

  fsr_bus_decode #(
    .OP_W     (8),
    .OP_RDSR  (OP_RDSR),
    .OP_CLRSR (OP_CLRSR)
  ) u_dec (
    .clk     (clk),
    .rst_i   (rst_i),
    .ce_n    (ce_n),
    .we_n    (we_n),
    .din     (din),
    .clr_cmd (clr_cmd),
    .rd_mode (rd_mode)
  );

  fsr_status_core u_core (
    .clk            (clk),
    .rst_i          (rst_i),
    .seq_start      (seq_start),
    .seq_done       (seq_done),
    .seq_susp_set   (seq_susp_set),
    .seq_susp_clr   (seq_susp_clr),
    .seq_erase_fail (seq_erase_fail),
    .seq_prog_fail  (seq_prog_fail),
    .op_confirm     (op_confirm),
    .vpp_ok         (vpp_ok),
    .clr_cmd        (clr_cmd),
    .status         (status),
    .lockout        (lockout)
  );

  fsr_read_port #(.SR_W(SR_W)) u_rd (
    .clk     (clk),
    .rst_i   (rst_i),
    .rd_mode (rd_mode),
    .ce_n    (ce_n),
    .oe_n    (oe_n),
    .status  (status),
    .dout    (dout),
    .dout_en (dout_en)
  );

  AST_PWRDN_EXIT: assert property (@(posedge clk)
    !pwrdn_n |=> (!lockout && !dout_en)); // R7
endmodule

// File: tb/tb_flash_status_ctrl.sv
module tb_flash_status_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1, pwrdn_n = 1'b1;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [7:0] din = 8'h00;
  logic [7:0] dout;
  logic dout_en, lockout;
  logic seq_start = 0, seq_done = 0, seq_susp_set = 0, seq_susp_clr = 0;
  logic seq_erase_fail = 0, seq_prog_fail = 0, op_confirm = 0, vpp_ok = 1;

  int checks = 0, errors = 0, cycles = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  flash_status_ctrl dut (
    .clk(clk), .rst(rst), .pwrdn_n(pwrdn_n), .ce_n(ce_n), .oe_n(oe_n),
    .we_n(we_n), .din(din), .dout(dout), .dout_en(dout_en),
    .seq_start(seq_start), .seq_done(seq_done), .seq_susp_set(seq_susp_set),
    .seq_susp_clr(seq_susp_clr), .seq_erase_fail(seq_erase_fail),
    .seq_prog_fail(seq_prog_fail), .op_confirm(op_confirm), .vpp_ok(vpp_ok),
    .lockout(lockout)
  );

  // Behavioural reference model
  bit m_ready, m_susp, m_rdm, m_wrp, m_rdp, m_en;
  bit [2:0] m_err; // [2] erase, [1] program, [0] supply
  bit [7:0] m_dout;
  always @(posedge clk) begin
    bit wr, pls, clr, rd;
    bit [7:0] snap;
    if (rst || !pwrdn_n) begin
      m_ready = 1; m_susp = 0; m_err = 0; m_rdm = 0;
      m_wrp = 0; m_rdp = 0; m_dout = 0; m_en = 0;
    end else begin
      wr   = !ce_n && !we_n;
      pls  = wr && !m_wrp;
      clr  = pls && din == 8'h50;
      snap = {m_ready, m_susp, m_err, 3'b000};
      rd   = m_rdm && !ce_n && !oe_n;
      if (!rd) m_dout = 0;
      else if (!m_rdp) m_dout = snap;
      m_en = rd; m_rdp = rd; m_wrp = wr;
      if (pls && din == 8'h70) m_rdm = 1;
      if (seq_start) m_ready = 0; else if (seq_done) m_ready = 1;
      if (seq_susp_set) m_susp = 1; else if (seq_susp_clr) m_susp = 0;
      if (seq_erase_fail) m_err[2] = 1; else if (clr) m_err[2] = 0;
      if (seq_prog_fail)  m_err[1] = 1; else if (clr) m_err[1] = 0;
      if (op_confirm && !vpp_ok) m_err[0] = 1; else if (clr) m_err[0] = 0;
    end
  end

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h at %0t", req, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model (R2 output, R3 hold, R6 lockout)
  always @(negedge clk) begin
    if (!rst && !finished) begin
      check("R2 model dout", dout, m_dout);
      check("R2 model dout_en", {7'd0, dout_en}, {7'd0, m_en});
      check("R6 model lockout", {7'd0, lockout}, {7'd0, |m_err});
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic bus_write(logic [7:0] op);
    @(negedge clk); din = op; ce_n = 0; we_n = 0;
    @(negedge clk); we_n = 1; ce_n = 1;
  endtask

  task automatic read_sr(output logic [7:0] v, output logic en);
    @(negedge clk); ce_n = 0; oe_n = 0;
    @(negedge clk); v = dout; en = dout_en;
    ce_n = 1; oe_n = 1;
    @(negedge clk);
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk); s = 1;
    @(negedge clk); s = 0;
  endtask

  initial begin
    logic [7:0] v;
    logic en;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R1 reset dout", dout, 8'h00);
    check("R6 reset lockout", {7'd0, lockout}, 8'h00);

    bus_write(8'h50);
    read_sr(v, en);
    check("R10 clear does not enter read mode", {7'd0, en}, 8'h00);

    bus_write(8'h70);
    read_sr(v, en);
    check("R1 reset value", v, 8'h80);
    check("R2 read enable", {7'd0, en}, 8'h01);

    pulse(seq_start);
    read_sr(v, en);
    check("R5 busy", v, 8'h00);
    pulse(seq_susp_set);
    bus_write(8'h50);
    read_sr(v, en);
    check("R5 clear keeps ready/suspend", v, 8'h40);
    pulse(seq_susp_clr);
    pulse(seq_done);
    read_sr(v, en);
    check("R5 done", v, 8'h80);

    // R3 frozen read
    @(negedge clk); ce_n = 0; oe_n = 0;
    @(negedge clk); check("R3 first capture", dout, 8'h80);
    seq_erase_fail = 1;
    @(negedge clk); seq_erase_fail = 0;
    @(negedge clk); check("R3 held during read", dout, 8'h80);
    check("R6 lockout on erase error", {7'd0, lockout}, 8'h01);
    oe_n = 1;
    @(negedge clk); oe_n = 0;
    @(negedge clk); check("R3 fresh capture after toggle", dout, 8'hA0);
    ce_n = 1; oe_n = 1;
    @(negedge clk);

    bus_write(8'hFF);
    read_sr(v, en);
    check("R10 unknown opcode keeps mode", {7'd0, en}, 8'h01);
    check("R4 error sticky", v, 8'hA0);
    bus_write(8'h50);
    read_sr(v, en);
    check("R4 cleared by command", v, 8'h80);
    check("R6 lockout released", {7'd0, lockout}, 8'h00);

    // R9 set and clear in one cycle
    @(negedge clk); din = 8'h50; ce_n = 0; we_n = 0; seq_prog_fail = 1;
    @(negedge clk); we_n = 1; ce_n = 1; seq_prog_fail = 0;
    read_sr(v, en);
    check("R9 set beats clear", v, 8'h90);
    bus_write(8'h50);

    // R8 supply sample
    @(negedge clk); vpp_ok = 0;
    repeat (2) @(negedge clk);
    vpp_ok = 1;
    read_sr(v, en);
    check("R8 no sample without confirm", v, 8'h80);
    @(negedge clk); vpp_ok = 0; op_confirm = 1;
    @(negedge clk); op_confirm = 0; vpp_ok = 1;
    read_sr(v, en);
    check("R8 supply error sampled", v, 8'h88);
    pulse(op_confirm);
    read_sr(v, en);
    check("R4 supply error sticky", v, 8'h88);

    // R7 power-down
    @(negedge clk); pwrdn_n = 0;
    @(negedge clk); pwrdn_n = 1;
    check("R7 lockout cleared", {7'd0, lockout}, 8'h00);
    read_sr(v, en);
    check("R7 read mode left", {7'd0, en}, 8'h00);
    bus_write(8'h70);
    read_sr(v, en);
    check("R7 value after power-down", v, 8'h80);

    repeat (3) @(negedge clk);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule